// File: doc/BRIEF.md
# Masking PRNG Reseed Scheduler

This block decides when the masking pseudo-random generator inside a cipher engine has to fetch fresh entropy. It counts completed cipher blocks against an interval chosen by a one-hot rate code. When the count reaches that interval, it raises a request to the entropy source and holds it until the source acknowledges. A pending-reseed trigger bit can also start a reseed. Software can set this bit directly, and a newly supplied key sets it when the key-touch enable is on. The bit is set by reset and clears itself when the reseed completes.

While a request is outstanding or the trigger bit is set, the block drives `busy` high so that the engine reports itself as not idle. The key-touch enable sits in a small auxiliary control word. That word can be frozen by clearing a lock-enable bit, and the lock-enable bit can only be cleared: it stays cleared until reset.

Top module: `reseed_sched`

## Requirements
- R1: The rate code selects how many counted blocks trigger a request. Code 3'b001 requests after every block, 3'b010 after RATE_MID blocks (default 64) and 3'b100 after RATE_SLOW blocks (default 8192). `entReq` rises in the cycle after the `blockDone` that completes the interval.
- R2: A rate code that is zero or has more than one bit set behaves exactly like 3'b001.
- R3: The block counter returns to zero when a reseed completes (`entReq` and `entAck` both high). It also returns to zero in any cycle where the normalised rate differs from that of the previous cycle, and a `blockDone` in that cycle is not counted.
- R4: Once raised, `entReq` stays high until it is sampled together with `entAck`, and it is low in the cycle after that.
- R5: A `blockDone` that arrives while `entReq` is high is not counted.
- R6: `reseedTrigger` is 1 during and after reset, so `entReq` rises in the first cycle after reset release. A completed reseed clears `reseedTrigger` unless a new set event arrives in the same cycle.
- R7: A `swTrigger` pulse sets `reseedTrigger` in the next cycle, and `entReq` rises one cycle after that.
- R8: A `keyWritten` pulse sets `reseedTrigger` only while `keyTouchEn` is 1. Otherwise it has no effect.
- R9: `busy` is 1 exactly when `entReq` or `reseedTrigger` is 1.
- R10: `keyTouchEn` resets to 1 and takes `auxKeyTouch` on `auxWe` only while `auxUnlocked` is 1. `auxUnlocked` resets to 1, is cleared by `lockWe` with `lockWrBit`=0, is not changed by `lockWe` with `lockWrBit`=1, and stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blockDone | input | 1 | One-cycle pulse per completed cipher block |
| rateCode | input | 3 | One-hot reseed interval select |
| keyWritten | input | 1 | Pulse when a new key has been supplied |
| swTrigger | input | 1 | Software pulse requesting a reseed |
| auxWe | input | 1 | Write strobe for the auxiliary control word |
| auxKeyTouch | input | 1 | New value of the key-touch enable |
| lockWe | input | 1 | Write strobe for the lock-enable bit |
| lockWrBit | input | 1 | Value written to the lock-enable bit (0 locks) |
| entAck | input | 1 | Entropy source acknowledge |
| entReq | output | 1 | Entropy request, held until acknowledged |
| busy | output | 1 | Reseed pending or in progress |
| reseedTrigger | output | 1 | Pending-reseed trigger bit |
| keyTouchEn | output | 1 | Key change forces reseed when 1 |
| auxUnlocked | output | 1 | Auxiliary control word still writable |

## Verification
A `blockDone` or `entAck` shows its effect on `entReq` one edge later. `swTrigger` and `keyWritten` move `reseedTrigger` and `busy` one edge later and `entReq` two edges later. The lock and aux writes land on their outputs one edge later. The bench drives each stimulus on a falling edge and samples on the next falling edge, so each result is checked in the cycle where it is due. It sweeps all eight rate codes with shortened intervals. For each code it checks silence up to one block before the interval and a request exactly at it.

// File: rtl/reseed_sched_pkg.sv
package reseed_sched_pkg;
  typedef enum logic [2:0] {
    RATE_EACH = 3'b001,
    RATE_MED  = 3'b010,
    RATE_LOW  = 3'b100
  } rate_e;

  typedef struct packed {
    logic clr;   // reseed completed: clear counter
    logic inc;   // counting allowed
  } cntStrobe_t;
endpackage

// File: rtl/reseed_count.sv
module reseed_count
  import reseed_sched_pkg::*;
#(
  parameter int RATE_MID  = 64,
  parameter int RATE_SLOW = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blockDone,
  input  logic [2:0] rateCode,
  input  cntStrobe_t strobe,
  output logic       rateHit
);
  localparam int CW  = $clog2(RATE_SLOW + 1);
  localparam int CW1 = CW + 1;

  rate_e          rateNorm, ratePrev;
  logic [CW-1:0]  cnt;
  logic [CW1-1:0] limit, cntInc;
  logic           rateChg;

  always_comb begin
    case (rateCode)
      3'b010:  rateNorm = RATE_MED;
      3'b100:  rateNorm = RATE_LOW;
      default: rateNorm = RATE_EACH;
    endcase
    case (rateNorm)
      RATE_MED: limit = CW1'(RATE_MID);
      RATE_LOW: limit = CW1'(RATE_SLOW);
      default:  limit = CW1'(1);
    endcase
  end

  assign rateChg = rateNorm != ratePrev;
  assign cntInc  = {1'b0, cnt} + 1'b1;
  assign rateHit = blockDone && strobe.inc && !rateChg && (cntInc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ratePrev <= RATE_EACH;
    end else begin
      ratePrev <= rateNorm;
      if (strobe.clr || rateChg) cnt <= '0;
      else if (blockDone && strobe.inc) cnt <= cntInc[CW-1:0];
    end
  end

  // R5
  hold_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.inc && !strobe.clr && !rateChg) |=> $stable(cnt));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rateChg |-> ({1'b0, cnt} <= limit));

  // R3
  clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clr |=> (cnt == '0));
endmodule

// File: rtl/reseed_ctrl.sv
module reseed_ctrl
  import reseed_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rateHit,
  input  logic       keyWritten,
  input  logic       swTrigger,
  input  logic       auxWe,
  input  logic       auxKeyTouch,
  input  logic       lockWe,
  input  logic       lockWrBit,
  input  logic       entAck,
  output cntStrobe_t strobe,
  output logic       entReq,
  output logic       busy,
  output logic       trigBit,
  output logic       keyTouchEn,
  output logic       lockEn
);
  logic setNow, ackNow;

  assign setNow = swTrigger || (keyWritten && keyTouchEn);
  assign ackNow = entReq && entAck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigBit    <= 1'b1;
      entReq     <= 1'b0;
      keyTouchEn <= 1'b1;
      lockEn     <= 1'b1;
    end else begin
      if (setNow)      trigBit <= 1'b1;
      else if (ackNow) trigBit <= 1'b0;

      if (ackNow)                            entReq <= 1'b0;
      else if (!entReq && (trigBit || rateHit)) entReq <= 1'b1;

      if (lockWe && !lockWrBit)  lockEn     <= 1'b0;
      if (auxWe && lockEn)       keyTouchEn <= auxKeyTouch;
    end
  end

  assign strobe.clr = ackNow;
  assign strobe.inc = !entReq;
  assign busy       = entReq || trigBit;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entReq && !entAck) |=> entReq);

  // R6
  trig_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trigBit && !entReq) |=> entReq);

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entReq && entAck && !swTrigger && !keyWritten) |=> !trigBit);

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lockEn |=> !lockEn);

  // R10
  locked_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lockEn |=> $stable(keyTouchEn));
endmodule

// File: rtl/reseed_sched.sv
module reseed_sched
  import reseed_sched_pkg::*;
#(
  parameter int RATE_MID  = 64,
  parameter int RATE_SLOW = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blockDone,
  input  logic [2:0] rateCode,
  input  logic       keyWritten,
  input  logic       swTrigger,
  input  logic       auxWe,
  input  logic       auxKeyTouch,
  input  logic       lockWe,
  input  logic       lockWrBit,
  input  logic       entAck,
  output logic       entReq,
  output logic       busy,
  output logic       reseedTrigger,
  output logic       keyTouchEn,
  output logic       auxUnlocked
);
  cntStrobe_t strobe;
  logic       rateHit;

  reseed_count #(.RATE_MID(RATE_MID), .RATE_SLOW(RATE_SLOW)) u_count (
    .clk(clk), .rst_n(rst_n), .blockDone(blockDone), .rateCode(rateCode),
    .strobe(strobe), .rateHit(rateHit)
  );

  reseed_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rateHit(rateHit), .keyWritten(keyWritten),
    .swTrigger(swTrigger), .auxWe(auxWe), .auxKeyTouch(auxKeyTouch),
    .lockWe(lockWe), .lockWrBit(lockWrBit), .entAck(entAck),
    .strobe(strobe), .entReq(entReq), .busy(busy), .trigBit(reseedTrigger),
    .keyTouchEn(keyTouchEn), .lockEn(auxUnlocked)
  );

  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entReq |-> busy);
endmodule

// File: tb/sim_reseed_sched.sv
`timescale 1ns/1ps
module sim_reseed_sched;
  localparam int MID  = 4;
  localparam int SLOW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic blockDone = 0, keyWritten = 0, swTrigger = 0, auxWe = 0;
  logic auxKeyTouch = 0, lockWe = 0, lockWrBit = 0, entAck = 0;
  logic [2:0] rateCode = 3'b001;
  logic entReq, busy, reseedTrigger, keyTouchEn, auxUnlocked;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  reseed_sched #(.RATE_MID(MID), .RATE_SLOW(SLOW)) u0 (
    .clk(clk), .rst_n(rst_n), .blockDone(blockDone), .rateCode(rateCode),
    .keyWritten(keyWritten), .swTrigger(swTrigger), .auxWe(auxWe),
    .auxKeyTouch(auxKeyTouch), .lockWe(lockWe), .lockWrBit(lockWrBit),
    .entAck(entAck), .entReq(entReq), .busy(busy),
    .reseedTrigger(reseedTrigger), .keyTouchEn(keyTouchEn),
    .auxUnlocked(auxUnlocked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sendBlock();
    blockDone = 1; tick(); blockDone = 0;
  endtask

  task automatic ackReq();
    entAck = 1; tick(); entAck = 0;
  endtask

  function automatic int expLimit(input int code);
    if (code == 2) return MID;
    if (code == 4) return SLOW;
    return 1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int early;
    @(negedge clk);
    // R6 reset state
    chk("R6 trigger in reset", reseedTrigger, 1);
    chk("R4 no req in reset", entReq, 0);
    chk("R9 busy in reset", busy, 1);
    chk("R10 keyTouchEn reset", keyTouchEn, 1);
    chk("R10 auxUnlocked reset", auxUnlocked, 1);
    rst_n = 1; tick();
    chk("R6 req after reset", entReq, 1);
    repeat (3) tick();
    chk("R4 req held", entReq, 1);
    chk("R9 busy while pending", busy, 1);
    ackReq();
    chk("R4 req dropped", entReq, 0);
    chk("R6 trigger cleared", reseedTrigger, 0);
    chk("R9 idle after reseed", busy, 0);

    // R1 / R2 sweep of all codes
    for (int c = 0; c < 8; c++) begin
      rateCode = 3'(c); tick();
      early = 0;
      for (int b = 0; b < expLimit(c) - 1; b++) begin
        sendBlock();
        if (entReq) early++;
      end
      chk($sformatf("R1 R2 code %0d early req", c), early, 0);
      sendBlock();
      chk($sformatf("R1 R2 code %0d req at limit", c), entReq, 1);
      ackReq();
      chk($sformatf("R3 code %0d req cleared", c), entReq, 0);
    end

    // R5 blocks ignored while pending, R3 clear on completion
    rateCode = 3'b010; tick();
    for (int b = 0; b < MID; b++) sendBlock();
    chk("R1 mid req", entReq, 1);
    for (int b = 0; b < 5; b++) sendBlock();
    ackReq();
    early = 0;
    for (int b = 0; b < MID - 1; b++) begin sendBlock(); if (entReq) early++; end
    chk("R5 pending blocks not counted", early, 0);
    sendBlock();
    chk("R5 req after fresh count", entReq, 1);
    ackReq();

    // R3 rate change clears counter
    rateCode = 3'b100; tick();
    for (int b = 0; b < 3; b++) sendBlock();
    rateCode = 3'b010; tick();
    early = 0;
    for (int b = 0; b < MID - 1; b++) begin sendBlock(); if (entReq) early++; end
    chk("R3 rate change cleared count", early, 0);
    sendBlock();
    chk("R3 req after change", entReq, 1);
    ackReq();

    // R7 software trigger
    swTrigger = 1; tick(); swTrigger = 0;
    chk("R7 trigger set", reseedTrigger, 1);
    chk("R7 req not yet", entReq, 0);
    chk("R9 busy from trigger", busy, 1);
    tick();
    chk("R7 req follows", entReq, 1);
    ackReq();
    chk("R7 trigger self-cleared", reseedTrigger, 0);

    // R8 key touch enabled
    keyWritten = 1; tick(); keyWritten = 0;
    chk("R8 key sets trigger", reseedTrigger, 1);
    tick(); ackReq();
    // R10 aux write while unlocked
    auxKeyTouch = 0; auxWe = 1; tick(); auxWe = 0;
    chk("R10 aux write applied", keyTouchEn, 0);
    keyWritten = 1; tick(); keyWritten = 0; tick();
    chk("R8 key ignored trigger", reseedTrigger, 0);
    chk("R8 key ignored req", entReq, 0);
    // R10 lock
    lockWrBit = 1; lockWe = 1; tick(); lockWe = 0;
    chk("R10 write 1 keeps unlock", auxUnlocked, 1);
    lockWrBit = 0; lockWe = 1; tick(); lockWe = 0;
    chk("R10 write 0 locks", auxUnlocked, 0);
    lockWrBit = 1; lockWe = 1; tick(); lockWe = 0;
    chk("R10 lock sticky", auxUnlocked, 0);
    auxKeyTouch = 1; auxWe = 1; tick(); auxWe = 0;
    chk("R10 locked aux ignored", keyTouchEn, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule